// File: doc/BRIEF.md
# IDE I/O Region Decoder with Drive Select

This block sits between a host I/O bus and the two channels of an IDE controller. Every host access carries an address, a byte count (1, 2 or 4) and, for writes, data. The block compares the address against five base registers: command and control blocks for the primary and secondary channels, and the bus-master register window. It then forwards the access one cycle later, with the matched target and the offset from that target's base. The bus-master window is shared by the two channels. Its lower half goes to the primary channel and its upper half to the secondary channel.

Each channel holds a latch that selects either the master drive or the slave drive. The latch is set by watching host writes to the drive/head register of that channel's command block. A forwarded command-block or control-block access carries the selected drive, and the access is sent only if that drive is present. Two enable bits, taken from writes to the command register, gate the block. I/O enable gates all decoding. Bus-master enable gates writes into the bus-master window.

Top module: `ide_io_decoder`

## Requirements
- R1: After reset both channels select the master drive, the sticky error flag is clear, I/O and bus-master enables are off, all base registers are 0, and no access is reported.
- R2: An access matches a region when base <= address < base + size. The sizes are: command blocks 8, control blocks 4, bus-master window 16. The forwarded offset is address minus base. All outputs are registered and appear in the cycle after the access.
- R3: When several regions match, the first match wins in this order: primary command, primary control, secondary command, secondary control, bus-master window. Target codes are 1 to 4 in that order, 5 for bus-master primary, 6 for bus-master secondary, and 0 for none.
- R4: A performed write to command-block offset 6 sets that channel's drive select from data bit 4 (1 = slave, 0 = master). The forwarded drive-select output of that same write already shows the new value.
- R5: While I/O enable is off, an access is acknowledged (done) but is not forwarded. It changes no drive select, sets no error and does not request all-ones read data.
- R6: While bus-master enable is off, writes to the bus-master window are dropped. Reads from the window are still forwarded.
- R7: In the bus-master window, offsets 0 to 7 go to the primary channel (target 5) with the same offset. Offsets 8 to 15 go to the secondary channel (target 6) with 8 subtracted.
- R8: A configuration write to base select 0 to 4 loads that base only when the data is nonzero. Select 5 loads I/O enable from data bit 0 and bus-master enable from data bit 2.
- R9: An enabled access with a byte count other than 1, 2 or 4, or to an address that matches no region, sets the sticky error flag and is not forwarded. For a read it asserts the all-ones data indication. The error flag is cleared only by reset.
- R10: Drive presence bits are: 0 primary master, 1 primary slave, 2 secondary master, 3 secondary slave. An access to a command or control block whose selected drive is absent is not forwarded, and a read asserts all-ones. A drive-select write still updates the latch.
- R11: Every access presented is acknowledged with done in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | 0-4 base register, 5 command register |
| cfgData | input | 16 | Configuration write data |
| accValid | input | 1 | Host access strobe |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSize | input | 3 | Byte count of the access |
| accAddr | input | 16 | I/O address |
| accWrData | input | 32 | Write data |
| drivePresent | input | 4 | Drive presence per R10 |
| accDone | output | 1 | Access acknowledged |
| fwdValid | output | 1 | Access forwarded to a target |
| fwdTarget | output | 3 | Target code per R3 |
| fwdOffset | output | 16 | Offset within the target |
| fwdWrite | output | 1 | Forwarded direction |
| fwdSize | output | 3 | Forwarded byte count |
| fwdData | output | 32 | Forwarded write data |
| fwdSlave | output | 1 | Selected drive of the channel (1 = slave) |
| rdAllOnes | output | 1 | Read completes with all-ones data |
| errFlag | output | 1 | Sticky decode error |
| priSlave | output | 1 | Primary channel drive select |
| secSlave | output | 1 | Secondary channel drive select |

## Verification
A drive/head write does two things in one cycle: it updates the channel's select latch, and it is forwarded to a drive chosen by that same new select. The bench provokes this by writing offset 6 with bit 4 set and then clear. It does this on a channel where both drives are present, and again on a channel whose slave is absent. The bench checks the latch outputs, the forwarded drive and whether the write itself was dropped against its own model on every clock. Overlapping regions while all bases are still zero are used in the same way to judge the decode priority.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NUM_REGIONS = 5;
  localparam int SEL_OFFSET  = 6;
  localparam int SEL_BIT     = 4;
  localparam int CFG_CMDREG  = 5;

  typedef enum logic [2:0] {
    TGT_NONE    = 3'd0,
    TGT_PRI_CMD = 3'd1,
    TGT_PRI_CTL = 3'd2,
    TGT_SEC_CMD = 3'd3,
    TGT_SEC_CTL = 3'd4,
    TGT_BM_PRI  = 3'd5,
    TGT_BM_SEC  = 3'd6
  } tgt_e;

  typedef struct packed {
    logic done;
    logic fwdEn;
    tgt_e tgt;
    logic slave;
    logic selUpd;
    logic selChan;
    logic selVal;
    logic errSet;
    logic allOnes;
  } strobe_t;
endpackage

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
#(
  parameter int AddrW      = 16,
  parameter int BmChanSize = 8
) (
  input  logic                   accValid,
  input  logic                   accWrite,
  input  logic [2:0]             accSize,
  input  logic                   selBit,
  input  logic [NUM_REGIONS-1:0] hitVec,
  input  logic [AddrW-1:0]       cmdOffPri,
  input  logic [AddrW-1:0]       cmdOffSec,
  input  logic [AddrW-1:0]       bmOff,
  input  logic                   ioEn,
  input  logic                   bmEn,
  input  logic [1:0]             curSel,
  input  logic [3:0]             drivePresent,
  output strobe_t                st
);
  logic       legal;
  logic       chan;
  logic       isCmd;
  logic       snoop;
  logic       selNext;
  tgt_e       chanTgt;
  logic [AddrW-1:0] cmdOff;

  assign legal = (accSize == 3'd1) || (accSize == 3'd2) || (accSize == 3'd4);

  always_comb begin
    chan    = 1'b0;
    isCmd   = 1'b0;
    chanTgt = TGT_NONE;
    if (hitVec[0])      begin chan = 1'b0; isCmd = 1'b1; chanTgt = TGT_PRI_CMD; end
    else if (hitVec[1]) begin chan = 1'b0; isCmd = 1'b0; chanTgt = TGT_PRI_CTL; end
    else if (hitVec[2]) begin chan = 1'b1; isCmd = 1'b1; chanTgt = TGT_SEC_CMD; end
    else if (hitVec[3]) begin chan = 1'b1; isCmd = 1'b0; chanTgt = TGT_SEC_CTL; end
    cmdOff  = chan ? cmdOffSec : cmdOffPri;
    snoop   = isCmd && accWrite && (cmdOff == AddrW'(SEL_OFFSET));
    selNext = snoop ? selBit : curSel[chan];
  end

  always_comb begin
    st = '0;
    if (accValid) begin
      st.done = 1'b1;
      if (ioEn) begin
        if (!legal || (hitVec == '0)) begin
          st.errSet  = 1'b1;
          st.allOnes = !accWrite;
        end else if (|hitVec[3:0]) begin
          st.selUpd  = snoop;
          st.selChan = chan;
          st.selVal  = selNext;
          st.slave   = selNext;
          if (drivePresent[{chan, selNext}]) begin
            st.fwdEn = 1'b1;
            st.tgt   = chanTgt;
          end else begin
            st.allOnes = !accWrite;
          end
        end else if (!(accWrite && !bmEn)) begin
          st.fwdEn = 1'b1;
          st.tgt   = (bmOff < AddrW'(BmChanSize)) ? TGT_BM_PRI : TGT_BM_SEC;
        end
      end
    end
  end

  // R9 R10
  always_comb begin
    fwd_err_excl_chk: assert (!(st.fwdEn && (st.errSet || st.allOnes)));
  end
endmodule

// File: rtl/ide_dec_path.sv
module ide_dec_path
  import ide_dec_pkg::*;
#(
  parameter int AddrW      = 16,
  parameter int DataW      = 32,
  parameter int CmdSize    = 8,
  parameter int CtlSize    = 4,
  parameter int BmSize     = 16,
  parameter int BmChanSize = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [2:0]                   cfgSel,
  input  logic [AddrW-1:0]             cfgData,
  input  logic                         accValid,
  input  logic                         accWrite,
  input  logic [2:0]                   accSize,
  input  logic [AddrW-1:0]             accAddr,
  input  logic [DataW-1:0]             accWrData,
  input  strobe_t                      st,
  output logic [NUM_REGIONS-1:0]       hitVec,
  output logic [AddrW-1:0]             cmdOffPri,
  output logic [AddrW-1:0]             cmdOffSec,
  output logic [AddrW-1:0]             bmOff,
  output logic                         ioEn,
  output logic                         bmEn,
  output logic [1:0]                   curSel,
  output logic                         accDone,
  output logic                         fwdValid,
  output logic [2:0]                   fwdTarget,
  output logic [AddrW-1:0]             fwdOffset,
  output logic                         fwdWrite,
  output logic [2:0]                   fwdSize,
  output logic [DataW-1:0]             fwdData,
  output logic                         fwdSlave,
  output logic                         rdAllOnes,
  output logic                         errFlag
);
  logic [NUM_REGIONS-1:0][AddrW-1:0] baseReg;
  logic [NUM_REGIONS-1:0][AddrW-1:0] regionOff;
  logic [AddrW-1:0]                  offSel;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    localparam int RSize = (g == 0 || g == 2) ? CmdSize :
                           ((g == 1 || g == 3) ? CtlSize : BmSize);
    logic [AddrW:0] limit;
    assign limit        = {1'b0, baseReg[g]} + (AddrW+1)'(RSize);
    assign hitVec[g]    = (accAddr >= baseReg[g]) && ({1'b0, accAddr} < limit);
    assign regionOff[g] = accAddr - baseReg[g];
  end

  assign cmdOffPri = regionOff[0];
  assign cmdOffSec = regionOff[2];
  assign bmOff     = regionOff[4];

  always_comb begin
    unique case (st.tgt)
      TGT_PRI_CMD: offSel = regionOff[0];
      TGT_PRI_CTL: offSel = regionOff[1];
      TGT_SEC_CMD: offSel = regionOff[2];
      TGT_SEC_CTL: offSel = regionOff[3];
      TGT_BM_PRI:  offSel = regionOff[4];
      TGT_BM_SEC:  offSel = regionOff[4] - AddrW'(BmChanSize);
      default:     offSel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      ioEn    <= 1'b0;
      bmEn    <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgSel < 3'(NUM_REGIONS)) begin
        if (cfgData != '0) baseReg[cfgSel] <= cfgData;
      end else if (cfgSel == 3'(CFG_CMDREG)) begin
        ioEn <= cfgData[0];
        bmEn <= cfgData[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel    <= '0;
      accDone   <= 1'b0;
      fwdValid  <= 1'b0;
      fwdTarget <= TGT_NONE;
      fwdOffset <= '0;
      fwdWrite  <= 1'b0;
      fwdSize   <= '0;
      fwdData   <= '0;
      fwdSlave  <= 1'b0;
      rdAllOnes <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (st.selUpd) curSel[st.selChan] <= st.selVal;
      accDone   <= st.done;
      fwdValid  <= st.fwdEn;
      fwdTarget <= st.fwdEn ? st.tgt : TGT_NONE;
      fwdOffset <= offSel;
      fwdWrite  <= accWrite;
      fwdSize   <= accSize;
      fwdData   <= accWrData;
      fwdSlave  <= st.slave;
      rdAllOnes <= st.allOnes;
      errFlag   <= errFlag | st.errSet;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R11
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> accDone);
  // R5
  io_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !ioEn) |=> (!fwdValid && !rdAllOnes && $stable(curSel)));
  // R4
  sel_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curSel) |-> $past(accValid && accWrite && ioEn));
  // R6
  bm_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdWrite && fwdTarget >= 3'(TGT_BM_PRI)) |-> $past(bmEn));
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int AddrW      = 16,
  parameter int DataW      = 32,
  parameter int CmdSize    = 8,
  parameter int CtlSize    = 4,
  parameter int BmSize     = 16,
  parameter int BmChanSize = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgSel,
  input  logic [AddrW-1:0] cfgData,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [2:0]       accSize,
  input  logic [AddrW-1:0] accAddr,
  input  logic [DataW-1:0] accWrData,
  input  logic [3:0]       drivePresent,
  output logic             accDone,
  output logic             fwdValid,
  output logic [2:0]       fwdTarget,
  output logic [AddrW-1:0] fwdOffset,
  output logic             fwdWrite,
  output logic [2:0]       fwdSize,
  output logic [DataW-1:0] fwdData,
  output logic             fwdSlave,
  output logic             rdAllOnes,
  output logic             errFlag,
  output logic             priSlave,
  output logic             secSlave
);
  strobe_t                st;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [AddrW-1:0]       cmdOffPri;
  logic [AddrW-1:0]       cmdOffSec;
  logic [AddrW-1:0]       bmOff;
  logic                   ioEn;
  logic                   bmEn;
  logic [1:0]             curSel;

  assign priSlave = curSel[0];
  assign secSlave = curSel[1];

  ide_dec_ctrl #(.AddrW(AddrW), .BmChanSize(BmChanSize)) u_ctrl (
    .accValid(accValid), .accWrite(accWrite), .accSize(accSize),
    .selBit(accWrData[SEL_BIT]), .hitVec(hitVec),
    .cmdOffPri(cmdOffPri), .cmdOffSec(cmdOffSec), .bmOff(bmOff),
    .ioEn(ioEn), .bmEn(bmEn), .curSel(curSel),
    .drivePresent(drivePresent), .st(st)
  );

  ide_dec_path #(
    .AddrW(AddrW), .DataW(DataW), .CmdSize(CmdSize), .CtlSize(CtlSize),
    .BmSize(BmSize), .BmChanSize(BmChanSize)
  ) u_path (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accAddr(accAddr), .accWrData(accWrData), .st(st),
    .hitVec(hitVec), .cmdOffPri(cmdOffPri), .cmdOffSec(cmdOffSec),
    .bmOff(bmOff), .ioEn(ioEn), .bmEn(bmEn), .curSel(curSel),
    .accDone(accDone), .fwdValid(fwdValid), .fwdTarget(fwdTarget),
    .fwdOffset(fwdOffset), .fwdWrite(fwdWrite), .fwdSize(fwdSize),
    .fwdData(fwdData), .fwdSlave(fwdSlave), .rdAllOnes(rdAllOnes),
    .errFlag(errFlag)
  );
endmodule

// File: tb/ide_io_decoder_bench.sv
`timescale 1ns/1ps
module ide_io_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [2:0]  cfgSel;
  logic [15:0] cfgData;
  logic        accValid;
  logic        accWrite;
  logic [2:0]  accSize;
  logic [15:0] accAddr;
  logic [31:0] accWrData;
  logic [3:0]  drivePresent;
  logic        accDone, fwdValid, fwdWrite, fwdSlave, rdAllOnes, errFlag;
  logic        priSlave, secSlave;
  logic [2:0]  fwdTarget, fwdSize;
  logic [15:0] fwdOffset;
  logic [31:0] fwdData;

  always #5 clk = ~clk;

  ide_io_decoder u_ide_io_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accAddr(accAddr), .accWrData(accWrData),
    .drivePresent(drivePresent), .accDone(accDone), .fwdValid(fwdValid),
    .fwdTarget(fwdTarget), .fwdOffset(fwdOffset), .fwdWrite(fwdWrite),
    .fwdSize(fwdSize), .fwdData(fwdData), .fwdSlave(fwdSlave),
    .rdAllOnes(rdAllOnes), .errFlag(errFlag), .priSlave(priSlave),
    .secSlave(secSlave)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int mBase[5];
  int mSize[5] = '{8, 4, 8, 4, 16};
  bit mIo, mBm, mErr;
  bit mSel[2];
  // expected outputs
  bit eDone, eFv, eOnes, eSlave, eChanTgt;
  int eTgt, eOff;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "accDone", accDone, eDone);
    chk(req, "fwdValid", fwdValid, eFv);
    chk(req, "rdAllOnes", rdAllOnes, eOnes);
    chk(req, "errFlag", errFlag, mErr);
    chk(req, "priSlave", priSlave, mSel[0]);
    chk(req, "secSlave", secSlave, mSel[1]);
    if (eFv) begin
      chk(req, "fwdTarget", fwdTarget, eTgt);
      chk(req, "fwdOffset", fwdOffset, eOff);
      chk(req, "fwdWrite", fwdWrite, accWrite);
      chk(req, "fwdSize", fwdSize, accSize);
      chk(req, "fwdData", fwdData, accWrData);
      if (eChanTgt) chk(req, "fwdSlave", fwdSlave, eSlave);
    end
  endtask

  // one clock: inputs already driven, model updated; compare after edge
  task automatic tick(string req);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic cfg(string req, int sel, int data);
    cfgWrEn = 1; cfgSel = 3'(sel); cfgData = 16'(data); accValid = 0;
    eDone = 0; eFv = 0; eOnes = 0; eChanTgt = 0;
    tick(req);
    if (sel < 5) begin
      if (data != 0) mBase[sel] = data;
    end else if (sel == 5) begin
      mIo = data[0]; mBm = data[2];
    end
    cfgWrEn = 0;
  endtask

  task automatic acc(string req, bit wr, int size, int addr, int data);
    int r;
    int s;
    int ch;
    cfgWrEn = 0; accValid = 1; accWrite = wr; accSize = 3'(size);
    accAddr = 16'(addr); accWrData = data;
    eDone = 1; eFv = 0; eOnes = 0; eSlave = 0; eTgt = 0; eOff = 0; eChanTgt = 0;
    if (mIo) begin
      r = -1;
      for (int i = 0; i < 5; i++)
        if (r < 0 && addr >= mBase[i] && addr < mBase[i] + mSize[i]) r = i;
      if (!(size == 1 || size == 2 || size == 4) || r < 0) begin
        mErr = 1; eOnes = !wr;
      end else if (r < 4) begin
        ch = r / 2;
        s = mSel[ch];
        if (r % 2 == 0 && wr && addr - mBase[r] == 6) begin
          s = data[4]; mSel[ch] = s[0];
        end
        eSlave = s[0]; eChanTgt = 1;
        if (drivePresent[ch * 2 + s]) begin
          eFv = 1; eTgt = r + 1; eOff = addr - mBase[r];
        end else eOnes = !wr;
      end else if (!(wr && !mBm)) begin
        eFv = 1; eOff = addr - mBase[4];
        if (eOff < 8) eTgt = 5;
        else begin eTgt = 6; eOff = eOff - 8; end
      end
    end
    tick(req);
    accValid = 0;
  endtask

  task automatic idle(string req);
    cfgWrEn = 0; accValid = 0;
    eDone = 0; eFv = 0; eOnes = 0; eChanTgt = 0;
    tick(req);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgSel = 0; cfgData = 0; accValid = 0;
    accWrite = 0; accSize = 1; accAddr = 0; accWrData = 0;
    drivePresent = 4'b0111;
    for (int i = 0; i < 5; i++) mBase[i] = 0;
    mIo = 0; mBm = 0; mErr = 0; mSel[0] = 0; mSel[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    idle("R1");
    // I/O disabled: acknowledged only (R5), done next cycle (R11)
    acc("R5", 1, 1, 6, 32'h10);
    acc("R11", 0, 1, 2, 0);
    cfg("R8", 5, 16'h0001);
    // all bases zero: overlap resolved by priority
    acc("R3", 0, 1, 5, 0);
    acc("R3", 0, 2, 9, 0);
    acc("R3", 0, 1, 15, 0);
    // program bases, zero write ignored
    cfg("R8", 0, 16'h01F0);
    cfg("R8", 1, 16'h03F4);
    cfg("R8", 2, 16'h0170);
    cfg("R8", 3, 16'h0374);
    cfg("R8", 4, 16'hC000);
    cfg("R8", 0, 0);
    acc("R8", 0, 1, 16'h01F2, 0);
    acc("R2", 0, 2, 16'h01F7, 0);
    acc("R2", 1, 4, 16'h03F5, 32'hA5A5_1234);
    acc("R2", 0, 1, 16'h0374, 0);
    acc("R2", 0, 1, 16'h01EF, 0);
    acc("R9", 0, 1, 16'h01F8, 0);
    acc("R9", 1, 3, 16'h01F0, 0);
    idle("R9");
    // drive select
    acc("R4", 1, 1, 16'h01F6, 32'h10);
    acc("R4", 0, 1, 16'h01F1, 0);
    acc("R4", 0, 1, 16'h03F6, 0);
    acc("R4", 1, 1, 16'h01F6, 32'hEF);
    acc("R4", 0, 1, 16'h01F3, 0);
    acc("R10", 1, 1, 16'h0176, 32'h10);
    acc("R10", 0, 1, 16'h0171, 0);
    acc("R10", 1, 2, 16'h0172, 32'h55);
    acc("R10", 0, 1, 16'h0376, 0);
    acc("R10", 1, 1, 16'h0176, 32'h00);
    acc("R10", 0, 1, 16'h0171, 0);
    // bus-master window
    acc("R6", 1, 1, 16'hC002, 32'h11);
    acc("R6", 0, 1, 16'hC00A, 0);
    cfg("R8", 5, 16'h0005);
    acc("R7", 1, 4, 16'hC004, 32'hDEAD_BEE0);
    acc("R7", 1, 1, 16'hC00A, 32'h22);
    acc("R7", 0, 1, 16'hC00F, 0);
    acc("R7", 0, 1, 16'hC007, 0);
    acc("R9", 0, 1, 16'hC010, 0);
    // disable I/O: snoop must not fire
    acc("R4", 1, 1, 16'h01F6, 32'h10);
    cfg("R8", 5, 16'h0004);
    acc("R5", 1, 1, 16'h01F6, 32'h00);
    acc("R5", 0, 1, 16'h9999, 0);
    idle("R11");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule